// File: doc/BRIEF.md
# Interrupt Controller Command Decoder and Register File

This block is the processor-facing front end of an eight-level interrupt controller. It watches a small asynchronous bus (a chip select, separate read and write strobes, one address bit and a byte-wide data path). Each completed write becomes either a step of the start-up configuration sequence or a run-time operation command. The block keeps the settings that result: vector base bits, trigger style, call spacing, cascade arrangement, the option byte, the level mask, special-mask state and the selection of which register a read returns. The neighbouring priority logic reads these settings as plain outputs.

End-of-interrupt and rotation commands leave the block as one-cycle strobes that carry a three-bit operation code and a level. The block does no priority arithmetic. It takes in the request vector, the in-service vector and the resolver's current winner, and only sends them back on reads. A poll read returns a status byte that was frozen when the poll was requested. That read also counts as an acknowledge, and the block reports it to the neighbour with a pulse.

Strobes are brought into the system clock through a synchronizer. A write or read takes effect a few clock cycles after its strobe rises. Reset is asynchronous and active low, and its release is synchronized.

Top module: `irq_cmd_regfile`

## Requirements
- R1: A write with a0=0 and data bit 4 set is the start word in every sequencer state. It restarts the sequence, clears the mask, turns special mask off, selects the request vector for reads, cancels a pending poll, and pulses `init_clr` for one cycle.
- R2: The start word loads `vec_lo` from bits 7..5, `level_trig` from bit 3, `interval4` from bit 2 and `single_mode` from bit 1. Bit 0 set means an option word will follow.
- R3: After the start word, the next a0=1 write loads `vec_hi` with the full byte. When `single_mode`=0, the a0=1 write after that loads `casc_cfg`. When an option word was requested, one more a0=1 write supplies it. `init_done` rises only after the last word of this sequence.
- R4: The option word sets `nest_special`=bit 4, `buffered`=bit 3, `master_sel`=bit 2, `auto_eoi`=bit 1 and `ptr_mode`=bit 0. If the start word did not request the option word, all five of these outputs are 0.
- R5: Until the sequence is complete, the mask keeps its value. This holds after reset too, when an a0=1 write before any start word is ignored.
- R6: Once the sequence is complete, an a0=1 write loads the mask, and a read with a0=1 returns the mask.
- R7: An a0=0 write with bits 4 and 3 clear is an operation word. Codes 001, 011, 101, 110 and 111 in bits 7..5 each give one `cmd_stb` cycle, with `cmd_code`=bits 7..5 and `cmd_level`=bits 2..0. Code 100 sets `aeoi_rot`, code 000 clears it, and code 010 does nothing. None of these three gives a strobe.
- R8: An a0=0 write with bit 4 clear and bit 3 set is a mode word. When bit 6 is set, `smm_on` takes bit 5. When bit 1 is set, `sel_isr` takes bit 0. A field whose enable bit is clear stays unchanged.
- R9: A read with a0=0 returns `isr_vec` when `sel_isr`=1 and `req_vec` otherwise. The selection persists across reads.
- R10: A mode word with bit 2 set freezes `poll_valid` and `poll_level`. The next completed read returns {valid, 0000, level} at either a0 value, and later input changes do not alter it. When that read completes, it clears the pending poll and, if valid was 1, pulses `poll_ack` once with `poll_ack_level`=level.
- R11: `dout_en` is high only while `cs_n` and `rd_n` are both low.
- R12: Strobes that occur while `cs_n` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; the command is taken at its rising edge |
| a0 | input | 1 | Address bit |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus |
| dout_en | output | 1 | Bus drive enable; when low the bus is released |
| req_vec | input | 8 | Request vector from the request register |
| isr_vec | input | 8 | In-service vector |
| poll_valid | input | 1 | Resolver has a pending winner |
| poll_level | input | 3 | Resolver's winning level |
| init_clr | output | 1 | One-cycle pulse on a start word (reset priority, edge detectors) |
| init_done | output | 1 | Configuration sequence complete |
| vec_lo | output | 3 | Low vector bits from the start word |
| vec_hi | output | 8 | High vector byte / pointer base |
| level_trig | output | 1 | 1 = level triggered, 0 = edge triggered |
| interval4 | output | 1 | 1 = call spacing of 4 |
| single_mode | output | 1 | 1 = no cascade |
| casc_cfg | output | 8 | Slave map (master) or identity (slave) |
| nest_special | output | 1 | Special nesting for cascades |
| buffered | output | 1 | Buffered bus mode |
| master_sel | output | 1 | Master when buffered |
| auto_eoi | output | 1 | Automatic end of interrupt |
| ptr_mode | output | 1 | Single-pointer acknowledge format |
| mask | output | 8 | Level mask |
| smm_on | output | 1 | Special mask active |
| sel_isr | output | 1 | Reads at a0=0 return the in-service vector |
| poll_busy | output | 1 | Poll requested, read not yet done |
| aeoi_rot | output | 1 | Rotate on automatic end of interrupt |
| cmd_stb | output | 1 | One-cycle operation strobe |
| cmd_code | output | 3 | Operation code with the strobe |
| cmd_level | output | 3 | Level with the strobe |
| poll_ack | output | 1 | One-cycle acknowledge from a valid poll read |
| poll_ack_level | output | 3 | Level acknowledged by the poll read |

## Verification
The bench drives both short and full configuration sequences, and it restarts the sequence with a start word while a mode is active. A design that counted words instead of following the single and option flags would put the wrong byte into `casc_cfg` or mark itself configured too early. A design that did not zero the option fields when the option word is skipped would keep auto-EOI from an earlier configuration.

The bench also changes the resolver inputs between the poll write and the poll read, and it polls with nothing pending. A design that did not freeze the poll data would return the later level. A design that acknowledged every poll read would pulse `poll_ack` with no request behind it.

Operation words with the no-strobe codes, mode words with clear enable bits, and writes with chip select high are each followed by a check that the state they could have touched has not changed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LVL_W  = 3;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_VEC   = 3'd1,
    SEQ_CASC  = 3'd2,
    SEQ_OPT   = 3'd3,
    SEQ_READY = 3'd4
  } seq_t;

  localparam logic [2:0] OP_AROT_CLR = 3'b000;
  localparam logic [2:0] OP_NOP      = 3'b010;
  localparam logic [2:0] OP_AROT_SET = 3'b100;

  function automatic logic op_strobes(input logic [2:0] code);
    return code[0] | (code[2] & code[1]);
  endfunction
endpackage

// File: rtl/irqc_strobe_sync.sv
module irqc_strobe_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned PW     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n,
  input  logic [PW-1:0] payload,
  output logic          fire,
  output logic [PW-1:0] held
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;
  logic [PW-1:0]     hold_q, hold_d;
  logic              hold_en;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], strobe_n};
    hold_en = ~chain_q[STAGES-1];
    hold_d  = payload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
      hold_q  <= '1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign fire = ~prev_q & chain_q[STAGES-1];
  assign held = hold_q;
endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              wa0,
  input  logic [BYTE_W-1:0] wd,
  output logic              start_wr,
  output logic              init_clr,
  output logic              init_done,
  output logic [2:0]        vec_lo,
  output logic [BYTE_W-1:0] vec_hi,
  output logic              level_trig,
  output logic              interval4,
  output logic              single_mode,
  output logic [BYTE_W-1:0] casc_cfg,
  output logic              nest_special,
  output logic              buffered,
  output logic              master_sel,
  output logic              auto_eoi,
  output logic              ptr_mode
);
  seq_t state_q, state_d;
  logic need_opt_q;
  logic hi_wr, vec_wr, casc_wr, opt_wr;
  logic [4:0] opt_q;

  assign start_wr = wr_go & ~wa0 & wd[4];
  assign hi_wr    = wr_go & wa0;
  assign vec_wr   = hi_wr & (state_q == SEQ_VEC);
  assign casc_wr  = hi_wr & (state_q == SEQ_CASC);
  assign opt_wr   = hi_wr & (state_q == SEQ_OPT);

  always_comb begin
    state_d = state_q;
    if (start_wr) begin
      state_d = SEQ_VEC;
    end else if (vec_wr) begin
      if (!single_mode)    state_d = SEQ_CASC;
      else if (need_opt_q) state_d = SEQ_OPT;
      else                 state_d = SEQ_READY;
    end else if (casc_wr) begin
      state_d = need_opt_q ? SEQ_OPT : SEQ_READY;
    end else if (opt_wr) begin
      state_d = SEQ_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      init_clr    <= 1'b0;
      vec_lo      <= '0;
      level_trig  <= 1'b0;
      interval4   <= 1'b0;
      single_mode <= 1'b0;
      need_opt_q  <= 1'b0;
      vec_hi      <= '0;
      casc_cfg    <= '0;
      opt_q       <= '0;
    end else begin
      state_q  <= state_d;
      init_clr <= start_wr;
      if (start_wr) begin
        vec_lo      <= wd[7:5];
        level_trig  <= wd[3];
        interval4   <= wd[2];
        single_mode <= wd[1];
        need_opt_q  <= wd[0];
        opt_q       <= '0;
      end
      if (vec_wr)  vec_hi   <= wd;
      if (casc_wr) casc_cfg <= wd;
      if (opt_wr)  opt_q    <= wd[4:0];
    end
  end

  assign init_done    = (state_q == SEQ_READY);
  assign nest_special = opt_q[4];
  assign buffered     = opt_q[3];
  assign master_sel   = opt_q[2];
  assign auto_eoi     = opt_q[1];
  assign ptr_mode     = opt_q[0];
endmodule

// File: rtl/irqc_op_regs.sv
module irqc_op_regs
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              wa0,
  input  logic [BYTE_W-1:0] wd,
  input  logic              start_wr,
  input  logic              ready,
  input  logic              rd_go,
  input  logic              poll_valid,
  input  logic [LVL_W-1:0]  poll_level,
  output logic [BYTE_W-1:0] mask,
  output logic              smm_on,
  output logic              sel_isr,
  output logic              poll_busy,
  output logic              frz_valid,
  output logic [LVL_W-1:0]  frz_level,
  output logic              aeoi_rot,
  output logic              cmd_stb,
  output logic [2:0]        cmd_code,
  output logic [LVL_W-1:0]  cmd_level,
  output logic              poll_ack,
  output logic [LVL_W-1:0]  poll_ack_level
);
  logic op_wr, mask_wr, ocw2_wr, ocw3_wr;
  logic mask_en, smm_en, sel_en, arot_en, poll_set, poll_done;
  logic smm_d, sel_d, arot_d, stb_d;
  logic [BYTE_W-1:0] mask_d;

  assign op_wr   = wr_go & ready & ~start_wr;
  assign mask_wr = op_wr & wa0;
  assign ocw2_wr = op_wr & ~wa0 & ~wd[3];
  assign ocw3_wr = op_wr & ~wa0 & wd[3];

  always_comb begin
    mask_en   = mask_wr | start_wr;
    mask_d    = start_wr ? '0 : wd;
    smm_en    = start_wr | (ocw3_wr & wd[6]);
    smm_d     = start_wr ? 1'b0 : wd[5];
    sel_en    = start_wr | (ocw3_wr & wd[1]);
    sel_d     = start_wr ? 1'b0 : wd[0];
    arot_en   = ocw2_wr & ((wd[7:5] == OP_AROT_SET) | (wd[7:5] == OP_AROT_CLR));
    arot_d    = wd[7];
    stb_d     = ocw2_wr & op_strobes(wd[7:5]);
    poll_set  = ocw3_wr & wd[2];
    poll_done = rd_go & poll_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask           <= '0;
      smm_on         <= 1'b0;
      sel_isr        <= 1'b0;
      aeoi_rot       <= 1'b0;
      poll_busy      <= 1'b0;
      frz_valid      <= 1'b0;
      frz_level      <= '0;
      cmd_stb        <= 1'b0;
      cmd_code       <= '0;
      cmd_level      <= '0;
      poll_ack       <= 1'b0;
      poll_ack_level <= '0;
    end else begin
      if (mask_en) mask     <= mask_d;
      if (smm_en)  smm_on   <= smm_d;
      if (sel_en)  sel_isr  <= sel_d;
      if (arot_en) aeoi_rot <= arot_d;
      cmd_stb <= stb_d;
      if (stb_d) begin
        cmd_code  <= wd[7:5];
        cmd_level <= wd[2:0];
      end
      if (start_wr) begin
        poll_busy <= 1'b0;
      end else if (poll_set) begin
        poll_busy <= 1'b1;
        frz_valid <= poll_valid;
        frz_level <= poll_level;
      end else if (poll_done) begin
        poll_busy <= 1'b0;
      end
      poll_ack <= poll_done & frz_valid;
      if (poll_done) poll_ack_level <= frz_level;
    end
  end
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
  import irqc_pkg::*;
(
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              a0,
  input  logic              poll_busy,
  input  logic              frz_valid,
  input  logic [LVL_W-1:0]  frz_level,
  input  logic              sel_isr,
  input  logic [BYTE_W-1:0] mask,
  input  logic [BYTE_W-1:0] req_vec,
  input  logic [BYTE_W-1:0] isr_vec,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_en
);
  localparam int unsigned PAD_W = BYTE_W - 1 - LVL_W;

  always_comb begin
    if (poll_busy)    dout = {frz_valid, {PAD_W{1'b0}}, frz_level};
    else if (a0)      dout = mask;
    else if (sel_isr) dout = isr_vec;
    else              dout = req_vec;
    dout_en = ~(cs_n | rd_n);
  end
endmodule

// File: rtl/irq_cmd_regfile.sv
module irq_cmd_regfile
  import irqc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              a0,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_en,
  input  logic [BYTE_W-1:0] req_vec,
  input  logic [BYTE_W-1:0] isr_vec,
  input  logic              poll_valid,
  input  logic [LVL_W-1:0]  poll_level,
  output logic              init_clr,
  output logic              init_done,
  output logic [2:0]        vec_lo,
  output logic [BYTE_W-1:0] vec_hi,
  output logic              level_trig,
  output logic              interval4,
  output logic              single_mode,
  output logic [BYTE_W-1:0] casc_cfg,
  output logic              nest_special,
  output logic              buffered,
  output logic              master_sel,
  output logic              auto_eoi,
  output logic              ptr_mode,
  output logic [BYTE_W-1:0] mask,
  output logic              smm_on,
  output logic              sel_isr,
  output logic              poll_busy,
  output logic              aeoi_rot,
  output logic              cmd_stb,
  output logic [2:0]        cmd_code,
  output logic [LVL_W-1:0]  cmd_level,
  output logic              poll_ack,
  output logic [LVL_W-1:0]  poll_ack_level
);
  localparam int unsigned WPAY_W = BYTE_W + 2;

  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic              wr_fire, rd_fire, rd_cs_n;
  logic [WPAY_W-1:0] wr_held;
  logic              wr_go, rd_go, wa0, start_wr;
  logic [BYTE_W-1:0] wd;
  logic              frz_valid;
  logic [LVL_W-1:0]  frz_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  irqc_strobe_sync #(.STAGES(SYNC_STAGES), .PW(WPAY_W)) u_wsync (
    .clk(clk), .rst_n(rst_s_n), .strobe_n(wr_n),
    .payload({cs_n, a0, din}), .fire(wr_fire), .held(wr_held)
  );

  irqc_strobe_sync #(.STAGES(SYNC_STAGES), .PW(1)) u_rsync (
    .clk(clk), .rst_n(rst_s_n), .strobe_n(rd_n),
    .payload(cs_n), .fire(rd_fire), .held(rd_cs_n)
  );

  assign wr_go = wr_fire & ~wr_held[WPAY_W-1];
  assign wa0   = wr_held[BYTE_W];
  assign wd    = wr_held[BYTE_W-1:0];
  assign rd_go = rd_fire & ~rd_cs_n;

  irqc_init_seq u_seq (
    .clk(clk), .rst_n(rst_s_n), .wr_go(wr_go), .wa0(wa0), .wd(wd),
    .start_wr(start_wr), .init_clr(init_clr), .init_done(init_done),
    .vec_lo(vec_lo), .vec_hi(vec_hi), .level_trig(level_trig),
    .interval4(interval4), .single_mode(single_mode), .casc_cfg(casc_cfg),
    .nest_special(nest_special), .buffered(buffered), .master_sel(master_sel),
    .auto_eoi(auto_eoi), .ptr_mode(ptr_mode)
  );

  irqc_op_regs u_ops (
    .clk(clk), .rst_n(rst_s_n), .wr_go(wr_go), .wa0(wa0), .wd(wd),
    .start_wr(start_wr), .ready(init_done), .rd_go(rd_go),
    .poll_valid(poll_valid), .poll_level(poll_level),
    .mask(mask), .smm_on(smm_on), .sel_isr(sel_isr), .poll_busy(poll_busy),
    .frz_valid(frz_valid), .frz_level(frz_level), .aeoi_rot(aeoi_rot),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_level(cmd_level),
    .poll_ack(poll_ack), .poll_ack_level(poll_ack_level)
  );

  irqc_read_mux u_rmux (
    .cs_n(cs_n), .rd_n(rd_n), .a0(a0), .poll_busy(poll_busy),
    .frz_valid(frz_valid), .frz_level(frz_level), .sel_isr(sel_isr),
    .mask(mask), .req_vec(req_vec), .isr_vec(isr_vec),
    .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic       clk,
  input logic       rst_s_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       dout_en,
  input logic       cmd_stb,
  input logic       poll_ack,
  input logic       poll_busy,
  input logic       init_clr,
  input logic       init_done,
  input logic       wr_go,
  input logic [7:0] mask,
  input logic       smm_on,
  input logic       sel_isr
);
  AST_HIZ_NO_CS: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_n |-> !dout_en) else $error("bus driven without select"); // R11
  AST_HIZ_NO_RD: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_n |-> !dout_en) else $error("bus driven without read"); // R11
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_stb |=> !cmd_stb) else $error("command strobe too long"); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    poll_ack |=> !poll_ack) else $error("poll ack too long"); // R10
  AST_ACK_ENDS_POLL: assert property (@(posedge clk) disable iff (!rst_s_n)
    poll_ack |-> !poll_busy) else $error("poll still pending after ack"); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    init_clr |-> (mask == 8'h00) && !smm_on && !sel_isr && !poll_busy)
    else $error("start word did not clear state"); // R1
  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mask != $past(mask)) |-> ($past(init_done) || init_clr))
    else $error("mask changed before configuration"); // R5
  AST_DONE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(init_done) |-> $past(wr_go)) else $error("configured without a write"); // R3
endmodule

bind irq_cmd_regfile irqc_checker u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .cs_n(cs_n), .rd_n(rd_n), .dout_en(dout_en),
  .cmd_stb(cmd_stb), .poll_ack(poll_ack), .poll_busy(poll_busy),
  .init_clr(init_clr), .init_done(init_done), .wr_go(wr_go), .mask(mask),
  .smm_on(smm_on), .sel_isr(sel_isr)
);

// File: tb/sim_irq_cmd_regfile.sv
`timescale 1ns/1ps
module sim_irq_cmd_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] req_vec = 8'h3C, isr_vec = 8'h81;
  logic poll_valid = 1'b0;
  logic [2:0] poll_level = 3'd0;
  logic [7:0] dout, vec_hi, casc_cfg, mask;
  logic dout_en, init_clr, init_done, level_trig, interval4, single_mode;
  logic nest_special, buffered, master_sel, auto_eoi, ptr_mode;
  logic smm_on, sel_isr, poll_busy, aeoi_rot, cmd_stb, poll_ack;
  logic [2:0] vec_lo, cmd_code, cmd_level, poll_ack_level;

  int n_chk = 0, n_fail = 0;
  int stb_cnt = 0, ack_cnt = 0, clr_cnt = 0;
  logic [2:0] last_code = '0, last_lvl = '0, last_ack_lvl = '0;
  logic [7:0] rdata;
  logic rd_en;

  always #5 clk = ~clk;

  irq_cmd_regfile u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .din(din), .dout(dout), .dout_en(dout_en), .req_vec(req_vec),
    .isr_vec(isr_vec), .poll_valid(poll_valid), .poll_level(poll_level),
    .init_clr(init_clr), .init_done(init_done), .vec_lo(vec_lo),
    .vec_hi(vec_hi), .level_trig(level_trig), .interval4(interval4),
    .single_mode(single_mode), .casc_cfg(casc_cfg),
    .nest_special(nest_special), .buffered(buffered), .master_sel(master_sel),
    .auto_eoi(auto_eoi), .ptr_mode(ptr_mode), .mask(mask), .smm_on(smm_on),
    .sel_isr(sel_isr), .poll_busy(poll_busy), .aeoi_rot(aeoi_rot),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_level(cmd_level),
    .poll_ack(poll_ack), .poll_ack_level(poll_ack_level)
  );

  always @(negedge clk) begin
    if (cmd_stb)  begin stb_cnt++; last_code = cmd_code; last_lvl = cmd_level; end
    if (poll_ack) begin ack_cnt++; last_ack_lvl = poll_ack_level; end
    if (init_clr) clr_cnt++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel_n, input logic addr, input logic [7:0] d);
    @(negedge clk); cs_n = sel_n; a0 = addr; din = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(input logic addr);
    @(negedge clk); cs_n = 1'b0; a0 = addr; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    rdata = dout; rd_en = dout_en;
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R3 init_done after reset", init_done, 0);
    check("R1 mask after reset", mask, 8'h00);
    check("R11 bus idle after reset", dout_en, 0);
    bus_wr(1'b0, 1'b1, 8'h55);
    bus_rd(1'b1);
    check("R5 mask write before start word ignored", rdata, 8'h00);
  endtask

  task automatic t_short_init;
    int c0;
    c0 = clr_cnt;
    bus_wr(1'b0, 1'b0, 8'hBE);
    check("R1 init_clr pulsed once", clr_cnt - c0, 1);
    check("R2 vec_lo", vec_lo, 3'b101);
    check("R2 level_trig", level_trig, 1);
    check("R2 interval4", interval4, 1);
    check("R2 single_mode", single_mode, 1);
    check("R3 not done after start word", init_done, 0);
    bus_wr(1'b0, 1'b1, 8'h48);
    check("R3 vec_hi", vec_hi, 8'h48);
    check("R3 done after vector word", init_done, 1);
    check("R5 vector word did not load mask", mask, 8'h00);
    check("R4 option fields zero", {nest_special, buffered, master_sel, auto_eoi, ptr_mode}, 5'b0);
  endtask

  task automatic t_full_init;
    bus_wr(1'b0, 1'b0, 8'h11);
    check("R2 cascade selected", single_mode, 0);
    bus_wr(1'b0, 1'b1, 8'h20);
    check("R3 waits for cascade word", init_done, 0);
    bus_wr(1'b0, 1'b1, 8'h84);
    check("R3 casc_cfg", casc_cfg, 8'h84);
    check("R3 waits for option word", init_done, 0);
    check("R5 mask unchanged mid sequence", mask, 8'h00);
    bus_wr(1'b0, 1'b1, 8'h17);
    check("R3 done after option word", init_done, 1);
    check("R4 option fields", {nest_special, buffered, master_sel, auto_eoi, ptr_mode}, 5'b10111);
    check("R3 vec_hi kept", vec_hi, 8'h20);
    bus_wr(1'b0, 1'b0, 8'hBE);
    bus_wr(1'b0, 1'b1, 8'h48);
    check("R4 option fields cleared without option word", {nest_special, buffered, master_sel, auto_eoi, ptr_mode}, 5'b0);
  endtask

  task automatic t_mask;
    bus_wr(1'b0, 1'b1, 8'hA5);
    bus_rd(1'b1);
    check("R6 mask readback", rdata, 8'hA5);
    bus_wr(1'b1, 1'b1, 8'hFF);
    bus_rd(1'b1);
    check("R12 write without select ignored", rdata, 8'hA5);
  endtask

  task automatic t_ocw2;
    int s0;
    s0 = stb_cnt;
    bus_wr(1'b0, 1'b0, 8'h65);
    check("R7 specific strobe count", stb_cnt - s0, 1);
    check("R7 strobe code", last_code, 3'b011);
    check("R7 strobe level", last_lvl, 3'd5);
    s0 = stb_cnt;
    bus_wr(1'b0, 1'b0, 8'h40);
    check("R7 no-op gives no strobe", stb_cnt - s0, 0);
    bus_wr(1'b0, 1'b0, 8'h80);
    check("R7 rotate-on-auto set", aeoi_rot, 1);
    check("R7 rotate-on-auto set no strobe", stb_cnt - s0, 0);
    bus_wr(1'b0, 1'b0, 8'h00);
    check("R7 rotate-on-auto clear", aeoi_rot, 0);
    check("R7 clear no strobe", stb_cnt - s0, 0);
    bus_wr(1'b0, 1'b0, 8'hC3);
    check("R7 set-priority strobe", stb_cnt - s0, 1);
    check("R7 set-priority code/level", {last_code, last_lvl}, {3'b110, 3'd3});
    bus_wr(1'b1, 1'b0, 8'h21);
    check("R12 unselected command no strobe", stb_cnt - s0, 1);
  endtask

  task automatic t_ocw3;
    bus_rd(1'b0);
    check("R9 request vector by default", rdata, 8'h3C);
    bus_wr(1'b0, 1'b0, 8'h0B);
    bus_rd(1'b0);
    check("R9 in-service selected", rdata, 8'h81);
    bus_rd(1'b0);
    check("R9 selection persists", rdata, 8'h81);
    bus_wr(1'b0, 1'b0, 8'h08);
    bus_rd(1'b0);
    check("R8 select unchanged without enable", rdata, 8'h81);
    bus_wr(1'b0, 1'b0, 8'h0A);
    bus_rd(1'b0);
    check("R8 back to request vector", rdata, 8'h3C);
    bus_wr(1'b0, 1'b0, 8'h68);
    check("R8 special mask on", smm_on, 1);
    bus_wr(1'b0, 1'b0, 8'h08);
    check("R8 special mask unchanged without enable", smm_on, 1);
    bus_wr(1'b0, 1'b0, 8'h48);
    check("R8 special mask off", smm_on, 0);
  endtask

  task automatic t_poll;
    int a0c;
    a0c = ack_cnt;
    poll_valid = 1'b1; poll_level = 3'd6;
    bus_wr(1'b0, 1'b0, 8'h0C);
    check("R10 poll pending", poll_busy, 1);
    poll_level = 3'd2;
    bus_rd(1'b1);
    check("R10 poll word frozen", rdata, 8'h86);
    check("R10 poll ack once", ack_cnt - a0c, 1);
    check("R10 poll ack level", last_ack_lvl, 3'd6);
    check("R10 poll cleared", poll_busy, 0);
    bus_rd(1'b1);
    check("R10 next read is mask", rdata, 8'hA5);
    poll_valid = 1'b0; poll_level = 3'd4;
    bus_wr(1'b0, 1'b0, 8'h0C);
    poll_valid = 1'b1;
    bus_rd(1'b0);
    check("R10 empty poll word", rdata, 8'h04);
    check("R10 empty poll no ack", ack_cnt - a0c, 1);
  endtask

  task automatic t_bus;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); check("R11 no drive without select", dout_en, 0);
    cs_n = 1'b0; rd_n = 1'b1;
    @(negedge clk); check("R11 no drive without read", dout_en, 0);
    rd_n = 1'b0;
    @(negedge clk); check("R11 drive on select and read", dout_en, 1);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_restart;
    bus_wr(1'b0, 1'b0, 8'h68);
    bus_wr(1'b0, 1'b0, 8'h0B);
    bus_wr(1'b0, 1'b0, 8'h0C);
    bus_wr(1'b0, 1'b0, 8'h1E);
    check("R1 mask cleared", mask, 8'h00);
    check("R1 special mask cleared", smm_on, 0);
    check("R1 read select cleared", sel_isr, 0);
    check("R1 poll cancelled", poll_busy, 0);
    check("R1 sequence restarted", init_done, 0);
    bus_wr(1'b0, 1'b1, 8'h00);
    check("R3 done again", init_done, 1);
  endtask

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_short_init();
    t_full_init();
    t_mask();
    t_ocw2();
    t_ocw3();
    t_poll();
    t_bus();
    t_restart();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule